// File: doc/BRIEF.md
# Prescaled Auto-Reload Down Timer

A 32-bit count-down timer behind a small word-addressed register port. Software first enables the timer clock, writes a start value while the timer is stopped, and then sets the run bit. Every 2^(ps+1) enabled ticks the count drops by one. The ps field is a 3-bit prescale value. A tick at which the count is already zero is an expiry. An expiry pulses the interrupt output for one cycle. In periodic mode the count then reloads the stored start value and keeps running. In one-shot mode the count stays at zero and the run bit clears itself.

The period between interrupts is (start value + 1) * 2^(ps+1) enabled ticks. A start value of all ones with reload on therefore gives a free-running 32-bit counter that interrupts once per wrap. Reads are combinational from the address, and return the live count.

Top module: `prescaled_down_timer`

## Requirements
- R1: After reset, the control word, the count and irq_o are all zero.
- R2: Address 0 is the control word. Its bits are 0 = clock enable, 1 = run, 2 = reload (periodic) and 5:3 = ps. It reads back with bits above 5 as zero. Address 1 is the write-only start value and reads 0. Address 2 is the read-only count, and writes to it are ignored. Address 3 reads 0.
- R3: A write to address 1 while clock enable = 1 and run = 0 stores the value. The count reads that value from the next cycle on.
- R4: A write to address 1 is ignored when clock enable = 0 or when run = 1.
- R5: The count changes only while clock enable and run are both 1, and only on cycles with tick_en_i high.
- R6: The count steps once every 2^(ps+1) cycles with tick_en_i high. The prescaler restarts from zero whenever counting is stopped.
- R7: An expiry is a count step taken at count zero. It drives irq_o high for exactly one cycle, in the cycle after that step. The first expiry comes (start+1)*2^(ps+1) cycles after the run-bit write when tick_en_i is held high.
- R8: With reload = 1, the count reloads the stored start value at each expiry and keeps running, giving a constant interrupt period.
- R9: With reload = 0, an expiry clears the run bit and leaves the count at zero. No further interrupts follow.
- R10: Clearing the run bit holds the count. Setting it again resumes counting from the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| tick_en_i | input | 1 | Tick enable feeding the prescaler |
| irq_o | output | 1 | One-cycle expiry pulse |

## Verification
A register write takes effect at the edge that samples it, so read-back is checked at the following falling edge. An interrupt is due exactly (start+1)*2^(ps+1) rising edges after the run-bit write edge. The bench counts falling edges from that write and compares the count at which irq_o first appears. The one-cycle width, the cleared run bit and the silence that follows are then each checked one falling edge at a time. Held and resumed counts are checked at edge numbers derived from the prescaler phase, which resets to zero whenever counting stops.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned PTV_W  = 3;
  localparam int unsigned CTRL_W = PTV_W + 3;
  localparam int unsigned PRE_W  = 2 ** PTV_W;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_LOAD = 2'd1;
  localparam logic [1:0] A_CNT  = 2'd2;

  typedef struct packed {
    logic [PTV_W-1:0] ptv;
    logic             auto_rl;
    logic             start;
    logic             clk_en;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [PTV_W-1:0] ptv_i,
  output logic             step_o
);
  localparam logic [PRE_W-1:0] ONES = '1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] limit;

  // limit = 2^(ptv+1) - 1
  assign limit  = ONES >> (PRE_W - 1 - int'(ptv_i));
  assign step_o = run_i && tick_i && (pre_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            pre_q <= '0;
    else if (!run_i)        pre_q <= '0;
    else if (step_o)        pre_q <= '0;
    else if (tick_i)        pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic             step_i,
  input  logic             auto_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q;

  assign count_o  = cnt_q;
  assign expire_o = step_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= expire_o;
      if (load_i)        cnt_q <= load_val_i;
      else if (expire_o) cnt_q <= auto_i ? reload_val_i : '0;
      else if (step_i)   cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/prescaled_down_timer.sv
module prescaled_down_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  input  logic             tick_en_i,
  output logic             irq_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] count;
  logic             ctrl_we, load_we, load_acc, run, step, expire;

  assign ctrl_we  = we_i && (addr_i == A_CTRL);
  assign load_we  = we_i && (addr_i == A_LOAD);
  assign load_acc = load_we && ctrl_q.clk_en && !ctrl_q.start;
  assign run      = ctrl_q.clk_en && ctrl_q.start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
    end else if (expire && !ctrl_q.auto_rl) begin
      ctrl_q.start <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       load_q <= '0;
    else if (load_acc) load_q <= wdata_i;
  end

  tmr_prescaler u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_i (tick_en_i),
    .ptv_i  (ctrl_q.ptv),
    .step_o (step)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load_acc),
    .load_val_i   (wdata_i),
    .reload_val_i (load_q),
    .step_i       (step),
    .auto_i       (ctrl_q.auto_rl),
    .count_o      (count),
    .expire_o     (expire),
    .irq_o        (irq_o)
  );

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
      A_CNT:   rdata_o = count;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_o,
  input logic             run,
  input logic             load_acc,
  input logic             load_we,
  input logic             ctrl_we,
  input logic             expire,
  input logic             auto_rl,
  input logic             start,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] load_q
);
  a_r7_irq_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  a_r5_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !load_acc) |=> $stable(count));

  a_r8_reload_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && auto_rl) |=> (count == load_q));

  a_r9_oneshot_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && !auto_rl && !ctrl_we) |=> !start);

  a_r4_load_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_we && start) |=> $stable(load_q));
endmodule

bind prescaled_down_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_o    (irq_o),
  .run      (run),
  .load_acc (load_acc),
  .load_we  (load_we),
  .ctrl_we  (ctrl_we),
  .expire   (expire),
  .auto_rl  (ctrl_q.auto_rl),
  .start    (ctrl_q.start),
  .count    (count),
  .load_q   (load_q)
);

// File: tb/sim_prescaled_down_timer.sv
`timescale 1ns/1ps
module sim_prescaled_down_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tick_en = 1'b1;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  prescaled_down_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_en_i(tick_en), .irq_o(irq)
  );

  localparam int NV = 5;
  localparam int V_PTV [NV] = '{0, 1, 2, 0, 3};
  localparam int V_LD  [NV] = '{3, 2, 1, 0, 0};
  localparam int V_EXP [NV] = '{8, 12, 16, 2, 16};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!irq && n < 5000);
  endtask

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    int seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 32'h0);
    rd(2'd2, v); chk("R1 count", v, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);

    // R2 register map
    wr(2'd0, 32'hFFFF_FFEE);
    rd(2'd0, v); chk("R2 ctrl readback", v, 32'h2E);
    wr(2'd0, 32'h0);
    rd(2'd1, v); chk("R2 load reads zero", v, 32'h0);
    rd(2'd3, v); chk("R2 addr3 zero", v, 32'h0);
    wr(2'd2, 32'd123);
    rd(2'd2, v); chk("R2 count write ignored", v, 32'h0);

    // R4 load ignored with clock enable off
    wr(2'd1, 32'd5);
    rd(2'd2, v); chk("R4 load blocked clk_en=0", v, 32'h0);

    // R3 load accepted
    wr(2'd0, 32'h1);
    wr(2'd1, 32'd9);
    rd(2'd2, v); chk("R3 load visible", v, 32'd9);

    // R6 R7 R9 vector table, one-shot
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, 32'(V_PTV[i] << 3) | 32'h1);
      wr(2'd1, 32'(V_LD[i]));
      wr(2'd0, 32'(V_PTV[i] << 3) | 32'h3);
      wait_irq(n);
      chk("R6/R7 period", 32'(n), 32'(V_EXP[i]));
      rd(2'd0, v); chk("R9 run cleared", v & 32'h2, 32'h0);
      rd(2'd2, v); chk("R9 count zero", v, 32'h0);
      @(negedge clk);
      chk("R7 one-cycle pulse", {31'd0, irq}, 32'h0);
      seen = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (irq) seen++;
      end
      chk("R9 no further irq", 32'(seen), 32'h0);
    end

    // R8 periodic
    wr(2'd0, 32'h1);
    wr(2'd1, 32'd2);
    wr(2'd0, 32'h7);
    wait_irq(n); chk("R8 first period", 32'(n), 32'd6);
    wait_irq(n); chk("R8 second period", 32'(n), 32'd6);
    wr(2'd1, 32'd50);
    wait_irq(n); chk("R4 load ignored while running", 32'(n), 32'd4);
    wait_irq(n); chk("R8 third period", 32'(n), 32'd6);
    wr(2'd0, 32'h1);

    // R5 tick gating
    wr(2'd1, 32'd20);
    @(negedge clk); tick_en = 1'b0;
    wr(2'd0, 32'h3);
    repeat (10) @(negedge clk);
    rd(2'd2, v); chk("R5 no tick no count", v, 32'd20);
    tick_en = 1'b1;
    repeat (4) @(negedge clk);
    rd(2'd2, v); chk("R5 counting resumes", v, 32'd18);

    // R10 hold and resume
    wr(2'd0, 32'h1);
    rd(2'd2, v); chk("R10 count at stop", v, 32'd17);
    repeat (10) @(negedge clk);
    rd(2'd2, v); chk("R10 held", v, 32'd17);
    wr(2'd0, 32'h3);
    repeat (4) @(negedge clk);
    rd(2'd2, v); chk("R10 resumed", v, 32'd15);
    wr(2'd0, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule